// File: doc/BRIEF.md
# UART Interrupt Mask and Event Latch

This block combines the interrupt causes of a serial port into one interrupt request line. The host programs an 8-bit enable register. Each set bit lets one cause drive the output, except bit 4, which is a sleep-mode control with no interrupt role.

Four causes are levels owned by neighbouring logic:
- receive data ready;
- transmit holding empty;
- any of four receive error flags;
- any of four modem-status change flags.

Three causes are events, and the block latches each one in a sticky pending flag:
- a pulse from the software flow-control stop-character detector;
- a low-to-high transition on the clear-to-send pin;
- a low-to-high transition on the request-to-send pin.

The host clears each pending flag with its own acknowledge strobe. Both pins are asynchronous, so each passes through a synchronizer before its edge is detected. The interrupt request is a registered output, so it cannot glitch.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, the enable register reads 0x00, `sleep_en` is 0 and `irq` is 0.
- R2: A cycle with `en_we` high loads `en_wdata` into the register, and `en_q` shows it from the next cycle on. `en_q` holds its value in every cycle without `en_we`. `sleep_en` always equals bit 4 of the register.
- R3: `rx_ready` is gated by bit 0 and `tx_empty` by bit 1. Both are level causes.
- R4: Bit 2 gates the line-status cause, which is active while any bit of `line_err[3:0]` is 1.
- R5: Bit 3 gates the modem-status cause, which is active while any bit of `modem_delta[3:0]` is 1.
- R6: A one-cycle pulse on `xoff_det` sets a pending flag, which bit 5 gates. The flag stays set until a pulse on `ack[0]` clears it.
- R7: A low-to-high transition on `rts_pin` sets a pending flag, which bit 6 gates, and `ack[1]` clears it. A pin held high or falling sets nothing.
- R8: A low-to-high transition on `cts_pin` sets a pending flag, which bit 7 gates, and `ack[2]` clears it. The same rules as for the request pin apply.
- R9: Bit 4 never causes `irq`.
- R10: Pending flags are latched whatever the enable bits are. Clearing an enable bit masks its flag but does not clear it, so setting the bit again brings `irq` back with no new event.
- R11: `irq` is registered. It reflects the enables and causes present at the previous clock edge.
- R12: When a set event and its acknowledge arrive in the same cycle, the flag ends up set.
- R13: Pin edges reach the pending flag after the synchronizer, which is `SYNC_STAGES` flops (default 2). After reset, a pin that is already low or high raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_we | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| en_q | output | 8 | Enable register contents |
| sleep_en | output | 1 | Sleep-mode control (bit 4) |
| rx_ready | input | 1 | Receive data ready level |
| tx_empty | input | 1 | Transmit holding empty level |
| line_err | input | 4 | Receive error flags |
| modem_delta | input | 4 | Modem-status change flags |
| xoff_det | input | 1 | Stop-character detected pulse |
| cts_pin | input | 1 | Clear-to-send pin, asynchronous |
| rts_pin | input | 1 | Request-to-send pin, asynchronous |
| ack | input | 3 | Acknowledge strobes: [0] stop-character, [1] request pin, [2] clear pin |
| irq | output | 1 | Registered interrupt request |

## Verification
- **Enable register:** a wrong bit shows on `en_q` at once, and on `irq` one cycle after a level cause is applied.
- **Lost or stuck pending flag:** the fault stays invisible while its enable bit is clear. Once the bit is set, `irq` goes wrong within one cycle, either missing after an event or staying high after an acknowledge.
- **Pin edge detection:** a broken detector shows on `irq` about four cycles after the pin moves. It shows either as a missed interrupt or as a second interrupt while the pin is held high.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int REG_W    = 8;
  localparam int BIT_RXR  = 0;
  localparam int BIT_TXE  = 1;
  localparam int BIT_LSE  = 2;
  localparam int BIT_MSE  = 3;
  localparam int BIT_SLP  = 4;
  localparam int BIT_XOF  = 5;
  localparam int BIT_RTS  = 6;
  localparam int BIT_CTS  = 7;
  localparam int N_EVT    = 3;   // sticky events: 0 xoff, 1 rts, 2 cts
  localparam logic [REG_W-1:0] SRC_MASK = ~(REG_W'(1) << BIT_SLP);
endpackage

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (we) q_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end
endmodule

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      assign sync_d = pin;
    end else begin : g_many
      assign sync_d = {sync_q[STAGES-2:0], pin};
    end
  endgenerate

  // reset high: a pin already high at reset release gives no edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/irq_sticky.sv
module irq_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] pend
);
  logic [N-1:0] pend_d;

  // set wins over a simultaneous clear so no event is lost
  always_comb pend_d = set | (pend & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= pend_d;
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_we,
  input  logic [REG_W-1:0] en_wdata,
  output logic [REG_W-1:0] en_q,
  output logic             sleep_en,
  input  logic             rx_ready,
  input  logic             tx_empty,
  input  logic [3:0]       line_err,
  input  logic [3:0]       modem_delta,
  input  logic             xoff_det,
  input  logic             cts_pin,
  input  logic             rts_pin,
  input  logic [N_EVT-1:0] ack,
  output logic             irq
);
  logic [N_EVT-1:0] evt_set;
  logic [N_EVT-1:0] pend_q;
  logic [REG_W-1:0] cause;
  logic             irq_d;
  logic [1:0]       pins;
  logic [1:0]       rises;

  irq_enable_reg #(.W(REG_W)) u_en (
    .clk(clk), .rst_n(rst_n), .we(en_we), .wdata(en_wdata), .q(en_q)
  );

  assign pins = {cts_pin, rts_pin};

  generate
    for (genvar i = 0; i < 2; i++) begin : g_pin
      irq_edge_sync #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin(pins[i]), .rise(rises[i])
      );
    end
  endgenerate

  assign evt_set = {rises[1], rises[0], xoff_det};

  irq_sticky #(.N(N_EVT)) u_pend (
    .clk(clk), .rst_n(rst_n), .set(evt_set), .clr(ack), .pend(pend_q)
  );

  always_comb begin
    cause          = '0;
    cause[BIT_RXR] = rx_ready;
    cause[BIT_TXE] = tx_empty;
    cause[BIT_LSE] = |line_err;
    cause[BIT_MSE] = |modem_delta;
    cause[BIT_XOF] = pend_q[0];
    cause[BIT_RTS] = pend_q[1];
    cause[BIT_CTS] = pend_q[2];
    irq_d          = |(cause & en_q & SRC_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end

  assign sleep_en = en_q[BIT_SLP];
endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en_we,
  input logic [7:0] en_wdata,
  input logic [7:0] en_q,
  input logic       xoff_det,
  input logic [2:0] ack,
  input logic       rx_ready,
  input logic [2:0] pend,
  input logic       irq
);
  p_write_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> en_q == $past(en_wdata));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we |=> $stable(en_q));
  p_sleep_no_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(en_q) & 8'hEF) != 8'h00);
  p_rx_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ready && en_q[0]) |=> irq);
  p_xoff_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_det |=> pend[0]);
  p_xoff_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[0] && !xoff_det) |=> !pend[0]);
  p_xoff_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[0] && !ack[0]) |=> pend[0]);
endmodule

bind uart_irq_ctrl uart_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en_we(en_we), .en_wdata(en_wdata), .en_q(en_q),
  .xoff_det(xoff_det), .ack(ack), .rx_ready(rx_ready), .pend(pend_q), .irq(irq)
);

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en_we;
  logic [7:0] en_wdata;
  logic [7:0] en_q;
  logic       sleep_en;
  logic       rx_ready, tx_empty, xoff_det, cts_pin, rts_pin, irq;
  logic [3:0] line_err, modem_delta;
  logic [2:0] ack;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  uart_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .en_we(en_we), .en_wdata(en_wdata), .en_q(en_q),
    .sleep_en(sleep_en), .rx_ready(rx_ready), .tx_empty(tx_empty),
    .line_err(line_err), .modem_delta(modem_delta), .xoff_det(xoff_det),
    .cts_pin(cts_pin), .rts_pin(rts_pin), .ack(ack), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_en(input logic [7:0] v);
    en_we = 1'b1; en_wdata = v;
    @(negedge clk);
    en_we = 1'b0;
  endtask

  task automatic pulse_ack(input int idx);
    ack[idx] = 1'b1;
    @(negedge clk);
    ack = '0;
  endtask

  // rising edge on a pin, checked with enable bit `bitn`, acknowledged with `ai`
  task automatic pin_test(input bit is_cts, input string tag);
    int ai = is_cts ? 2 : 1;
    if (is_cts) cts_pin = 1'b1; else rts_pin = 1'b1;
    cyc(5);
    chk(irq === 1'b1, {tag, " rise raises irq"}, irq, 1);
    pulse_ack(ai); cyc(1);
    chk(irq === 1'b0, {tag, " ack clears"}, irq, 0);
    cyc(5);
    chk(irq === 1'b0, {tag, " held high no new event"}, irq, 0);
    if (is_cts) cts_pin = 1'b0; else rts_pin = 1'b0;
    cyc(5);
    chk(irq === 1'b0, {tag, " fall no event"}, irq, 0);
  endtask

  initial begin
    cyc(20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en_we = 1'b0; en_wdata = '0;
    rx_ready = 0; tx_empty = 0; line_err = '0; modem_delta = '0;
    xoff_det = 0; cts_pin = 0; rts_pin = 0; ack = '0;
    cyc(3);
    rst_n = 1'b1;
    cyc(6);
    // R1 / R13: reset defaults, no event from static pins
    chk(en_q === 8'h00, "R1 enable reset", en_q, 0);
    chk(sleep_en === 1'b0, "R1 sleep reset", sleep_en, 0);
    chk(irq === 1'b0, "R1 irq reset", irq, 0);
    set_en(8'hFF);
    chk(irq === 1'b0, "R13 no event after reset", irq, 0);
    cyc(1);
    chk(irq === 1'b0, "R13 no event after reset late", irq, 0);

    // Sweep all enable values against every level cause (R2 R3 R4 R5 R9 R11)
    for (int e = 0; e < 256; e++) begin
      set_en(e[7:0]);
      chk(en_q === e[7:0], "R2 readback", en_q, e);
      chk(sleep_en === e[4], "R2 sleep bit", sleep_en, e[4]);
      cyc(1);
      chk(irq === 1'b0, "R9 idle no irq", irq, 0);
      for (int s = 0; s < 10; s++) begin
        int b;
        if (s == 0) begin rx_ready = 1; b = 0; end
        else if (s == 1) begin tx_empty = 1; b = 1; end
        else if (s < 6) begin line_err[s-2] = 1'b1; b = 2; end
        else begin modem_delta[s-6] = 1'b1; b = 3; end
        @(negedge clk);
        chk(irq === e[b], (b < 2) ? "R3 level cause" : (b == 2) ? "R4 line status" : "R5 modem status",
            irq, e[b]);
        rx_ready = 0; tx_empty = 0; line_err = '0; modem_delta = '0;
        @(negedge clk);
        chk(irq === 1'b0, "R11 irq follows removal", irq, 0);
      end
    end

    // Stop-character event (R6 R10 R12)
    set_en(8'hE0);
    xoff_det = 1; @(negedge clk); xoff_det = 0;
    chk(irq === 1'b0, "R11 one-cycle latency", irq, 0);
    cyc(1);
    chk(irq === 1'b1, "R6 xoff raises irq", irq, 1);
    set_en(8'h00); cyc(1);
    chk(irq === 1'b0, "R10 mask drops irq", irq, 0);
    set_en(8'hE0); cyc(1);
    chk(irq === 1'b1, "R10 unmask restores irq", irq, 1);
    pulse_ack(0); cyc(1);
    chk(irq === 1'b0, "R6 ack clears", irq, 0);
    xoff_det = 1; ack[0] = 1; @(negedge clk); xoff_det = 0; ack = '0;
    cyc(1);
    chk(irq === 1'b1, "R12 set beats ack", irq, 1);
    pulse_ack(0); cyc(1);
    chk(irq === 1'b0, "R6 ack clears again", irq, 0);

    // Pin edges (R7 R8 R13)
    pin_test(1'b0, "R7");
    pin_test(1'b1, "R8");
    // cross-gating: RTS edge latched while only CTS enabled (R10 R7)
    set_en(8'h80);
    rts_pin = 1; cyc(5);
    chk(irq === 1'b0, "R7 masked by bit 6", irq, 0);
    set_en(8'h40); cyc(1);
    chk(irq === 1'b1, "R10 latched while masked", irq, 1);
    pulse_ack(1); cyc(1);
    chk(irq === 1'b0, "R7 ack clears", irq, 0);
    rts_pin = 0; cyc(3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule